// File: doc/BRIEF.md
# Oscillator Configuration Register Bank

This block holds the settings of a programmable clock oscillator in a small byte-addressed register file. A host reaches it through a plain parallel port: an address, a write strobe with a data byte, and a combinational read-data byte that follows the address. In a full chip this port sits behind a two-wire serial slave. The decoded settings are also driven straight to the oscillator core. These are the output divider, a dither-depth select, a 10-bit frequency DAC word, a frequency window offset, a device address with a write-control bit, and a fixed base-range value.

The bank keeps a nonvolatile shadow copy of every writable field. A write to a command address copies the working set into the shadow and starts a busy window, during which all writes are dropped. Each release of the working reset reloads the working set from the shadow, so committed settings survive a reset and uncommitted ones are lost. A separate power-on reset puts the shadow back to its factory values. One DAC step is worth 10 kHz, and one offset step moves the frequency window by 5.12 MHz. The offset window spans six steps either side of the base range value.

Top module: `osc_cfg_regs`

## Requirements
- R1: Register map: 02h holds the divider in bits 3:0 and the dither select in bit 4; 0Dh holds the device address in bits 2:0 and the write-control bit in bit 3; 0Eh holds the 5-bit window offset in bits 4:0. Each reads back what was written, its unused bits read as zero, and the fields appear on the matching output ports.
- R2: The 10-bit DAC word is left-justified. Register 08h holds bits 9:2. Bits 7:6 of register 09h hold bits 1:0, and bits 5:0 of 09h read as zero. The word appears on dac_o.
- R3: Register 37h is read-only and returns the RANGE_OS parameter in bits 4:0. Writes to it change nothing.
- R4: An access to any address outside the map, or a read of 3Fh, returns zero. A write to an unmapped address changes no register.
- R5: A write to 3Fh while idle copies all writable fields into the shadow and raises busy_o for exactly BUSY_CYCLES cycles, starting at the next clock edge.
- R6: While busy_o is high, every write is ignored, including a write to 3Fh.
- R7: When rst_ni is released, the working registers load from the shadow on the first clock edge. Committed values return and uncommitted writes are discarded.
- R8: After power-on reset (por_ni low), the shadow holds the defaults: divider 0, dither 0, DAC 1F4h (08h reads 7Dh, 09h reads 00h), device address 0, write-control 0, and offset equal to RANGE_OS. busy_o is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset of the working set; reloads it from the shadow |
| por_ni | input | 1 | Active-low async power-on reset of the shadow to defaults |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| busy_o | output | 1 | Commit to the shadow in progress |
| div_o | output | 4 | Output divider setting |
| dither_o | output | 1 | Dither depth select |
| dac_o | output | 10 | Frequency DAC word |
| dev_addr_o | output | 3 | Device address |
| wc_o | output | 1 | Write-control bit |
| ofs_o | output | 5 | Frequency window offset |
| range_o | output | 5 | Fixed base range value |

## Verification
The bench writes all-ones to every register so that an unmasked spare bit shows up. A wrong mask reads back as a nonzero pad bit. A DAC word that is not left-justified puts bits 1:0 in the wrong place in 09h. The bench writes the read-only and unmapped addresses and then reads every register again, to catch a decoder that aliases those writes onto a real field. It counts the busy window cycle by cycle and writes during it. An off-by-one counter, or a write path that ignores busy, changes the count or the stored divider. Finally, it resets with and without power-on reset. A design that reloads the defaults on every reset, or that never copies the working set, returns the wrong DAC bytes.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int DAC_W  = 10;
  localparam int DIV_W  = 4;
  localparam int DEV_W  = 3;
  localparam int OFS_W  = 5;
  localparam int LO_W   = DAC_W - DATA_W;  // DAC bits held in the low register
  localparam int NREG   = 7;

  localparam int IDX_DIV = 0;
  localparam int IDX_DACH = 1;
  localparam int IDX_DACL = 2;
  localparam int IDX_DEV = 3;
  localparam int IDX_OFS = 4;
  localparam int IDX_RNG = 5;
  localparam int IDX_EE = 6;

  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] =
    '{8'h02, 8'h08, 8'h09, 8'h0D, 8'h0E, 8'h37, 8'h3F};

  localparam logic [DAC_W-1:0] DAC_DEFAULT = 10'h1F4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             dither;
    logic [DAC_W-1:0] dac;
    logic [DEV_W-1:0] dev;
    logic             wc;
    logic [OFS_W-1:0] ofs;
  } cfg_t;
endpackage

// File: rtl/osc_cfg_decode.sv
module osc_cfg_decode
  import osc_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = (addr_i == REG_ADDR[i]);
  end
endmodule

// File: rtl/osc_cfg_shadow.sv
module osc_cfg_shadow
  import osc_cfg_pkg::*;
#(
  parameter int   BUSY_CYCLES = 8,
  parameter cfg_t DEFAULT_CFG = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic commit_i,
  input  cfg_t cfg_i,
  output cfg_t shadow_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  cfg_t             shadow_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       shadow_q <= DEFAULT_CFG;
    else if (commit_i) shadow_q <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (commit_i)     cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign shadow_o = shadow_q;
  assign busy_o   = (cnt_q != '0);

  assert_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    commit_i |=> (shadow_q == $past(cfg_i)) && busy_o);
  assert_busy_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (busy_o && !commit_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_cfg_pkg::*;
#(
  parameter int               BUSY_CYCLES = 8,
  parameter logic [OFS_W-1:0] RANGE_OS    = 5'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              dither_o,
  output logic [DAC_W-1:0]  dac_o,
  output logic [DEV_W-1:0]  dev_addr_o,
  output logic              wc_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [OFS_W-1:0]  range_o
);
  localparam cfg_t CFG_DEFAULT = '{div: '0, dither: 1'b0, dac: DAC_DEFAULT,
                                   dev: '0, wc: 1'b0, ofs: RANGE_OS};

  logic [NREG-1:0] sel;
  cfg_t            cfg_q;
  cfg_t            shadow_cfg;
  logic            load_q;
  logic            busy;
  logic            wr_ok;
  logic            commit;

  osc_cfg_decode u_dec (.addr_i(addr_i), .sel_o(sel));

  assign wr_ok  = wr_en_i && !busy && !load_q;
  assign commit = wr_ok && sel[IDX_EE];

  osc_cfg_shadow #(.BUSY_CYCLES(BUSY_CYCLES), .DEFAULT_CFG(CFG_DEFAULT)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .commit_i(commit),
    .cfg_i(cfg_q), .shadow_o(shadow_cfg), .busy_o(busy)
  );

  // first edge after reset release copies the shadow in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_DEFAULT;
      load_q <= 1'b1;
    end else if (load_q) begin
      cfg_q  <= shadow_cfg;
      load_q <= 1'b0;
    end else if (wr_ok) begin
      if (sel[IDX_DIV]) begin
        cfg_q.div    <= wdata_i[DIV_W-1:0];
        cfg_q.dither <= wdata_i[DIV_W];
      end
      if (sel[IDX_DACH]) cfg_q.dac[DAC_W-1:LO_W] <= wdata_i;
      if (sel[IDX_DACL]) cfg_q.dac[LO_W-1:0]     <= wdata_i[DATA_W-1 -: LO_W];
      if (sel[IDX_DEV]) begin
        cfg_q.dev <= wdata_i[DEV_W-1:0];
        cfg_q.wc  <= wdata_i[DEV_W];
      end
      if (sel[IDX_OFS]) cfg_q.ofs <= wdata_i[OFS_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel[IDX_DIV])  rdata_o = DATA_W'({cfg_q.dither, cfg_q.div});
    if (sel[IDX_DACH]) rdata_o = cfg_q.dac[DAC_W-1:LO_W];
    if (sel[IDX_DACL]) rdata_o = {cfg_q.dac[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
    if (sel[IDX_DEV])  rdata_o = DATA_W'({cfg_q.wc, cfg_q.dev});
    if (sel[IDX_OFS])  rdata_o = DATA_W'(cfg_q.ofs);
    if (sel[IDX_RNG])  rdata_o = DATA_W'(RANGE_OS);
  end

  assign busy_o     = busy;
  assign div_o      = cfg_q.div;
  assign dither_o   = cfg_q.dither;
  assign dac_o      = cfg_q.dac;
  assign dev_addr_o = cfg_q.dev;
  assign wc_o       = cfg_q.wc;
  assign ofs_o      = cfg_q.ofs;
  assign range_o    = RANGE_OS;

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  assert_range_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && !load_q && sel[IDX_RNG]) |=> $stable(cfg_q));
  assert_unmapped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && !load_q && !(|sel)) |=> $stable(cfg_q));
  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && !load_q && busy) |=> $stable(cfg_q));
  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    load_q |=> (cfg_q == $past(shadow_cfg)));
endmodule

// File: tb/sim_osc_cfg_regs.sv
module sim_osc_cfg_regs;
  localparam int BUSY = 8;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h02, 8'h00, 8'h00, 8'd8},
    '{1'b0, 8'h08, 8'h00, 8'h7D, 8'd8},
    '{1'b0, 8'h09, 8'h00, 8'h00, 8'd8},
    '{1'b0, 8'h0E, 8'h00, 8'h10, 8'd8},
    '{1'b0, 8'h37, 8'h00, 8'h10, 8'd3},
    '{1'b1, 8'h02, 8'hFF, 8'h1F, 8'd1},
    '{1'b1, 8'h08, 8'hA5, 8'hA5, 8'd2},
    '{1'b1, 8'h09, 8'hFF, 8'hC0, 8'd2},
    '{1'b1, 8'h0D, 8'hFF, 8'h0F, 8'd1},
    '{1'b1, 8'h0E, 8'h0B, 8'h0B, 8'd1},
    '{1'b1, 8'h37, 8'h05, 8'h10, 8'd3},
    '{1'b1, 8'h50, 8'hAA, 8'h00, 8'd4},
    '{1'b0, 8'h3F, 8'h00, 8'h00, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;
  logic [3:0] div;
  logic       dither;
  logic [9:0] dac;
  logic [2:0] dev;
  logic       wc;
  logic [4:0] ofs;
  logic [4:0] rng;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osc_cfg_regs #(.BUSY_CYCLES(BUSY), .RANGE_OS(5'd16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .div_o(div), .dither_o(dither),
    .dac_o(dac), .dev_addr_o(dev), .wc_o(wc), .ofs_o(ofs), .range_o(rng)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic do_reset(input bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 busy after reset", {31'd0, busy}, 32'd0);
    check("R8 dac default", {22'd0, dac}, 32'h1F4);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].wdata);
      rd_check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
    end

    // R1 R2: field ports; R4: unmapped write left every field intact
    check("R2 dac_o", {22'd0, dac}, 32'h297);
    check("R1 div_o", {28'd0, div}, 32'hF);
    check("R1 dither_o", {31'd0, dither}, 32'd1);
    check("R1 dev_addr_o", {29'd0, dev}, 32'd7);
    check("R1 wc_o", {31'd0, wc}, 32'd1);
    check("R1 ofs_o", {27'd0, ofs}, 32'h0B);
    check("R3 range_o", {27'd0, rng}, 32'h10);
    wr(8'h00, 8'hFF);
    rd_check("R4 unmapped 00 read", 8'h00, 8'h00);
    rd_check("R4 div after unmapped write", 8'h02, 8'h1F);
    rd_check("R4 dac hi after unmapped write", 8'h08, 8'hA5);
    rd_check("R4 dac lo after unmapped write", 8'h09, 8'hC0);
    rd_check("R4 dev after unmapped write", 8'h0D, 8'h0F);
    rd_check("R4 ofs after unmapped write", 8'h0E, 8'h0B);

    // R5 commit and busy length, R6 writes dropped while busy
    @(negedge clk);
    addr = 8'h3F; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    addr = 8'h02; wdata = 8'h00;   // attempted write during busy
    hi = 0;
    for (int c = 0; c < BUSY + 4; c++) begin
      if (busy) hi++;
      @(negedge clk);
      if (c == 1) begin addr = 8'h3F; end
      if (c == 2) wr_en = 1'b0;
    end
    wr_en = 1'b0;
    check("R5 busy length", hi, BUSY);
    check("R5 busy cleared", {31'd0, busy}, 32'd0);
    rd_check("R6 div unchanged by write during busy", 8'h02, 8'h1F);

    // R7 uncommitted write lost, committed values return
    wr(8'h08, 8'h11);
    rd_check("R7 uncommitted write visible", 8'h08, 8'h11);
    do_reset(1'b0);
    rd_check("R7 dac hi reloaded", 8'h08, 8'hA5);
    rd_check("R7 dac lo reloaded", 8'h09, 8'hC0);
    rd_check("R7 div reloaded", 8'h02, 8'h1F);
    rd_check("R7 ofs reloaded", 8'h0E, 8'h0B);

    // R8 power-on reset restores defaults
    do_reset(1'b1);
    rd_check("R8 dac hi default", 8'h08, 8'h7D);
    rd_check("R8 dac lo default", 8'h09, 8'h00);
    rd_check("R8 div default", 8'h02, 8'h00);
    rd_check("R8 dev default", 8'h0D, 8'h00);
    rd_check("R8 ofs default", 8'h0E, 8'h10);
    check("R8 busy low", {31'd0, busy}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule